// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block parks a processor in one of three low-power modes and brings it back to full speed. The core writes a two-bit mode field and then pulses an idle-entry strobe. The controller then moves to the chosen mode and drives the enables for the oscillator, PLL, core clock, system clock and watchdog to match that mode. Each mode accepts its own set of wake-up inputs, and all of those inputs are active low.

The lightest mode leaves every clock running and resumes on any interrupt. The middle mode keeps the oscillator and watchdog alive, gates the core and system clocks, and resumes on a watchdog event or on a selected source that a mask allows. A selected source counts only after it has been held low for a programmed number of oscillator cycles. The deepest mode stops every clock and resumes only on the non-maskable interrupt, and only when that input is enabled. Asynchronous reset always returns the block to normal running.

A resume from either of the two deeper modes brings the clocks back in a fixed order: oscillator, then core clock, then system clock. On the cycle when full operation returns, the block raises a one-cycle wake pulse toward the core. All pins are plain control and status signals, because no data stream passes through this block.

Top module: `lpm_clock_ctrl`

## Requirements
- R1: After reset the block is running: in_lpm=0, wake_pulse=0, and osc_en, pll_en, core_clk_en, sys_clk_en and wdog_run are all 1.
- R2: While running, idle_req=1 at a clock edge selects the mode from mode_sel: 2'b00 gives idle, 2'b01 gives standby, and 2'b10 or 2'b11 gives halt. in_lpm is 1 from the next cycle. idle_req has no effect in any other state.
- R3: In idle, every clock enable and wdog_run stays 1 and in_lpm=1.
- R4: In standby, osc_en, pll_en and wdog_run are 1, while core_clk_en and sys_clk_en are 0.
- R5: In halt, osc_en, pll_en, core_clk_en, sys_clk_en and wdog_run are all 0.
- R6: Idle ends at the edge where irq_n, wdint_n or dbg_n is low, or where nmi_n is low while nmi_en=1. The next cycle is running with wake_pulse=1.
- R7: In standby, wdint_n low ends the mode at once. Bit i of periph_wake_n takes part only when wake_mask[i]=1. nmi_n takes part only when nmi_en=1.
- R8: A standby source that takes part must be seen low at qual_cycles consecutive edges before it is accepted, with a value of 0 treated as 1. An edge at which no such source is low restarts the count.
- R9: Halt ends only when nmi_n is low while nmi_en=1. irq_n, wdint_n, dbg_n and periph_wake_n are ignored in halt.
- R10: A resume from standby or halt takes three cycles. In the first cycle osc_en=1, pll_en=1 and in_lpm=0. In the second, core_clk_en=1 is added. In the third, sys_clk_en=1 is added and wake_pulse=1.
- R11: wake_pulse is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Low-power mode selection |
| idle_req | input | 1 | Idle-entry strobe from the core |
| wake_mask | input | NSRC | Per-source standby wake enable |
| qual_cycles | input | QW | Qualification length in oscillator cycles |
| nmi_en | input | 1 | Enable for the non-maskable wake |
| irq_n | input | 1 | Any enabled interrupt, active low |
| nmi_n | input | 1 | Non-maskable interrupt, active low |
| wdint_n | input | 1 | Watchdog interrupt, active low |
| dbg_n | input | 1 | Debugger wake request, active low |
| periph_wake_n | input | NSRC | Peripheral wake sources, active low |
| in_lpm | output | 1 | Block is in a low-power mode |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| core_clk_en | output | 1 | Core clock enable |
| sys_clk_en | output | 1 | System clock output enable |
| wdog_run | output | 1 | Watchdog clock running |
| wake_pulse | output | 1 | One-cycle resume indication to the core |

## Verification
The hardest case to reach is a standby source that is released one cycle before its qualification count completes and then held for the full count. Random single-cycle pulses almost never produce either pattern. The directed stimulus holds one masked source low for exactly qual_cycles-1 edges, releases it, and then holds it for qual_cycles edges. The random phase makes each peripheral input sticky, changing only about once every eight cycles, so that long low stretches appear. Those stretches are checked against a cycle model in the bench.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_IDLE    = 3'd1,
    ST_STBY    = 3'd2,
    ST_HALT    = 3'd3,
    ST_WK_OSC  = 3'd4,
    ST_WK_CORE = 3'd5
  } lpm_state_e;

  typedef struct packed {
    logic lpm;
    logic osc;
    logic pll;
    logic core;
    logic sys;
    logic wdog;
  } clk_ctl_t;

  // Clock-enable pattern for each controller state
  function automatic clk_ctl_t ctl_for(lpm_state_e s);
    clk_ctl_t c;
    case (s)
      ST_IDLE:    c = '{lpm: 1'b1, osc: 1'b1, pll: 1'b1, core: 1'b1, sys: 1'b1, wdog: 1'b1};
      ST_STBY:    c = '{lpm: 1'b1, osc: 1'b1, pll: 1'b1, core: 1'b0, sys: 1'b0, wdog: 1'b1};
      ST_HALT:    c = '{lpm: 1'b1, osc: 1'b0, pll: 1'b0, core: 1'b0, sys: 1'b0, wdog: 1'b0};
      ST_WK_OSC:  c = '{lpm: 1'b0, osc: 1'b1, pll: 1'b1, core: 1'b0, sys: 1'b0, wdog: 1'b1};
      ST_WK_CORE: c = '{lpm: 1'b0, osc: 1'b1, pll: 1'b1, core: 1'b1, sys: 1'b0, wdog: 1'b1};
      default:    c = '{lpm: 1'b0, osc: 1'b1, pll: 1'b1, core: 1'b1, sys: 1'b1, wdog: 1'b1};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/lpm_wake_select.sv
module lpm_wake_select #(
  parameter int NSRC = 14
) (
  input  logic [NSRC-1:0] wake_mask,
  input  logic [NSRC-1:0] periph_wake_n,
  input  logic            nmi_en,
  input  logic            irq_n,
  input  logic            nmi_n,
  input  logic            wdint_n,
  input  logic            dbg_n,
  output logic            idle_wake,
  output logic            stby_fast,
  output logic            stby_qual_low,
  output logic            halt_wake
);

  logic [NSRC-1:0] src_low;
  logic            nmi_hit;

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_src
      assign src_low[gi] = wake_mask[gi] & ~periph_wake_n[gi];
    end
  endgenerate

  assign nmi_hit       = nmi_en & ~nmi_n;
  assign idle_wake     = ~irq_n | ~wdint_n | ~dbg_n | nmi_hit;
  assign stby_fast     = ~wdint_n;
  assign stby_qual_low = (|src_low) | nmi_hit;
  assign halt_wake     = nmi_hit;

endmodule

// File: rtl/lpm_qualifier.sv
module lpm_qualifier #(
  parameter int QW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          sig_low,
  input  logic [QW-1:0] limit,
  output logic          accept
);

  localparam int CW = QW + 1;

  logic [QW-1:0] cnt;
  logic [QW-1:0] lim_eff;
  logic          reached;

  assign lim_eff = (limit == '0) ? QW'(1) : limit;
  assign reached = sig_low && (({1'b0, cnt} + CW'(1)) >= {1'b0, lim_eff});
  assign accept  = reached && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear || !sig_low) begin
      cnt <= '0;
    end else if (!reached) begin
      cnt <= cnt + QW'(1);
    end
  end

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle_req,
  input  logic [1:0] mode_sel,
  input  logic       idle_wake,
  input  logic       stby_fast,
  input  logic       stby_accept,
  input  logic       halt_wake,
  output lpm_state_e state,
  output logic       wake_pulse
);

  lpm_state_e nxt;
  logic       pulse_nxt;

  always_comb begin
    nxt       = state;
    pulse_nxt = 1'b0;
    case (state)
      ST_RUN: begin
        if (idle_req) begin
          if (mode_sel[1])      nxt = ST_HALT;
          else if (mode_sel[0]) nxt = ST_STBY;
          else                  nxt = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (idle_wake) begin
          nxt       = ST_RUN;
          pulse_nxt = 1'b1;
        end
      end
      ST_STBY:    if (stby_fast || stby_accept) nxt = ST_WK_OSC;
      ST_HALT:    if (halt_wake) nxt = ST_WK_OSC;
      ST_WK_OSC:  nxt = ST_WK_CORE;
      ST_WK_CORE: begin
        nxt       = ST_RUN;
        pulse_nxt = 1'b1;
      end
      default:    nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      wake_pulse <= 1'b0;
    end else begin
      state      <= nxt;
      wake_pulse <= pulse_nxt;
    end
  end

endmodule

// File: rtl/lpm_clock_ctrl.sv
module lpm_clock_ctrl
  import lpm_pkg::*;
#(
  parameter int NSRC = 14,
  parameter int QW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode_sel,
  input  logic            idle_req,
  input  logic [NSRC-1:0] wake_mask,
  input  logic [QW-1:0]   qual_cycles,
  input  logic            nmi_en,
  input  logic            irq_n,
  input  logic            nmi_n,
  input  logic            wdint_n,
  input  logic            dbg_n,
  input  logic [NSRC-1:0] periph_wake_n,
  output logic            in_lpm,
  output logic            osc_en,
  output logic            pll_en,
  output logic            core_clk_en,
  output logic            sys_clk_en,
  output logic            wdog_run,
  output logic            wake_pulse
);

  lpm_state_e state;
  clk_ctl_t   ctl;
  logic       idle_wake, stby_fast, stby_qual_low, halt_wake, stby_accept;

  lpm_wake_select #(.NSRC(NSRC)) u_sel (
    .wake_mask     (wake_mask),
    .periph_wake_n (periph_wake_n),
    .nmi_en        (nmi_en),
    .irq_n         (irq_n),
    .nmi_n         (nmi_n),
    .wdint_n       (wdint_n),
    .dbg_n         (dbg_n),
    .idle_wake     (idle_wake),
    .stby_fast     (stby_fast),
    .stby_qual_low (stby_qual_low),
    .halt_wake     (halt_wake)
  );

  lpm_qualifier #(.QW(QW)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (state != ST_STBY),
    .sig_low (stby_qual_low),
    .limit   (qual_cycles),
    .accept  (stby_accept)
  );

  lpm_sequencer u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle_req    (idle_req),
    .mode_sel    (mode_sel),
    .idle_wake   (idle_wake),
    .stby_fast   (stby_fast),
    .stby_accept (stby_accept),
    .halt_wake   (halt_wake),
    .state       (state),
    .wake_pulse  (wake_pulse)
  );

  assign ctl         = ctl_for(state);
  assign in_lpm      = ctl.lpm;
  assign osc_en      = ctl.osc;
  assign pll_en      = ctl.pll;
  assign core_clk_en = ctl.core;
  assign sys_clk_en  = ctl.sys;
  assign wdog_run    = ctl.wdog;

endmodule

// File: rtl/lpm_clock_ctrl_checks.sv
module lpm_clock_ctrl_checks (
  input logic clk,
  input logic rst_n,
  input logic nmi_en,
  input logic nmi_n,
  input logic in_lpm,
  input logic osc_en,
  input logic pll_en,
  input logic core_clk_en,
  input logic sys_clk_en,
  input logic wdog_run,
  input logic wake_pulse
);

  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  assert_halt_all_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_lpm && !osc_en) |-> (!pll_en && !core_clk_en && !sys_clk_en && !wdog_run));

  assert_stby_wdog_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_lpm && osc_en && !core_clk_en) |-> (wdog_run && pll_en && !sys_clk_en));

  assert_sys_after_core_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_clk_en) |-> ($past(core_clk_en) && wake_pulse));

  assert_core_after_osc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clk_en) |-> ($past(osc_en) && !in_lpm));

  assert_halt_exit_nmi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_lpm && !osc_en) && osc_en) |-> $past(nmi_en && !nmi_n));

endmodule

bind lpm_clock_ctrl lpm_clock_ctrl_checks u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .nmi_en      (nmi_en),
  .nmi_n       (nmi_n),
  .in_lpm      (in_lpm),
  .osc_en      (osc_en),
  .pll_en      (pll_en),
  .core_clk_en (core_clk_en),
  .sys_clk_en  (sys_clk_en),
  .wdog_run    (wdog_run),
  .wake_pulse  (wake_pulse)
);

// File: tb/lpm_clock_ctrl_test.sv
`timescale 1ns/1ps
module lpm_clock_ctrl_test;

  localparam int NSRC = 14;
  localparam int QW   = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      mode_sel = 2'b00;
  logic            idle_req = 1'b0;
  logic [NSRC-1:0] wake_mask = '0;
  logic [QW-1:0]   qual_cycles = '0;
  logic            nmi_en = 1'b0;
  logic            irq_n = 1'b1, nmi_n = 1'b1, wdint_n = 1'b1, dbg_n = 1'b1;
  logic [NSRC-1:0] periph_wake_n = '1;
  logic in_lpm, osc_en, pll_en, core_clk_en, sys_clk_en, wdog_run, wake_pulse;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit model_on = 1'b0;

  always #2 clk = ~clk;

  lpm_clock_ctrl #(.NSRC(NSRC), .QW(QW)) uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .idle_req(idle_req),
    .wake_mask(wake_mask), .qual_cycles(qual_cycles), .nmi_en(nmi_en),
    .irq_n(irq_n), .nmi_n(nmi_n), .wdint_n(wdint_n), .dbg_n(dbg_n),
    .periph_wake_n(periph_wake_n), .in_lpm(in_lpm), .osc_en(osc_en),
    .pll_en(pll_en), .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en),
    .wdog_run(wdog_run), .wake_pulse(wake_pulse)
  );

  // Expected {in_lpm,osc,pll,core,sys,wdog,pulse}; states:
  // 0 run, 1 idle, 2 standby, 3 halt, 4 resume-osc, 5 resume-core
  function automatic logic [6:0] exp_vec(int st, bit p);
    case (st)
      1:       return {6'b111111, p};
      2:       return {6'b111001, p};
      3:       return {6'b100000, p};
      4:       return {6'b011001, p};
      5:       return {6'b011101, p};
      default: return {6'b011111, p};
    endcase
  endfunction

  function automatic logic [6:0] act_vec();
    return {in_lpm, osc_en, pll_en, core_clk_en, sys_clk_en, wdog_run, wake_pulse};
  endfunction

  task automatic check(string req, logic [6:0] exp);
    checks++;
    if (act_vec() !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act_vec(), exp);
    end
  endtask

  task automatic enter(logic [1:0] m);
    mode_sel = m;
    idle_req = 1'b1;
    @(negedge clk);
    idle_req = 1'b0;
  endtask

  // Bench cycle model used during the random phase
  int ms = 0, mc = 0;
  bit mp = 1'b0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms <= 0; mc <= 0; mp <= 1'b0;
    end else begin
      bit lowq;
      int lim;
      mp <= 1'b0;
      lowq = (|(wake_mask & ~periph_wake_n)) || (nmi_en && !nmi_n);
      lim  = (qual_cycles == 0) ? 1 : int'(qual_cycles);
      if (ms != 2) mc <= 0;
      case (ms)
        0: if (idle_req) ms <= mode_sel[1] ? 3 : (mode_sel[0] ? 2 : 1);
        1: if (!irq_n || !wdint_n || !dbg_n || (nmi_en && !nmi_n)) begin
             ms <= 0; mp <= 1'b1;
           end
        2: begin
             if (!wdint_n) ms <= 4;
             else if (lowq) begin
               if (mc + 1 >= lim) ms <= 4;
               else mc <= mc + 1;
             end else mc <= 0;
           end
        3: if (nmi_en && !nmi_n) ms <= 4;
        4: ms <= 5;
        default: begin ms <= 0; mp <= 1'b1; end
      endcase
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", exp_vec(0, 0));

    // Idle entry and exit
    enter(2'b00);
    check("R2 R3 idle entry", exp_vec(1, 0));
    wake_mask = '1; periph_wake_n = '0;
    @(negedge clk);
    check("R6 idle ignores peripheral wake", exp_vec(1, 0));
    periph_wake_n = '1;
    irq_n = 1'b0;
    @(negedge clk);
    irq_n = 1'b1;
    check("R6 idle exit on irq", exp_vec(0, 1));
    @(negedge clk);
    check("R11 pulse single", exp_vec(0, 0));

    // idle_req ignored in a low-power mode
    enter(2'b00);
    enter(2'b10);
    check("R2 idle_req ignored in idle", exp_vec(1, 0));
    dbg_n = 1'b0;
    @(negedge clk);
    dbg_n = 1'b1;
    check("R6 idle exit on debugger", exp_vec(0, 1));

    // Standby: mask and qualification
    wake_mask = 14'h0008;
    qual_cycles = 8'd5;
    enter(2'b01);
    check("R4 standby clocks", exp_vec(2, 0));
    periph_wake_n[0] = 1'b0;
    nmi_n = 1'b0;
    irq_n = 1'b0;
    repeat (10) @(negedge clk);
    check("R7 masked source and disabled nmi ignored", exp_vec(2, 0));
    periph_wake_n[0] = 1'b1; nmi_n = 1'b1; irq_n = 1'b1;
    periph_wake_n[3] = 1'b0;
    repeat (4) @(negedge clk);
    periph_wake_n[3] = 1'b1;
    check("R8 short low not accepted", exp_vec(2, 0));
    repeat (3) @(negedge clk);
    check("R8 still standby after release", exp_vec(2, 0));
    periph_wake_n[3] = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 four of five edges", exp_vec(2, 0));
    @(negedge clk);
    periph_wake_n[3] = 1'b1;
    check("R10 resume osc step", exp_vec(4, 0));
    @(negedge clk);
    check("R10 resume core step", exp_vec(5, 0));
    @(negedge clk);
    check("R10 resume sys step with pulse", exp_vec(0, 1));
    @(negedge clk);
    check("R11 pulse drops", exp_vec(0, 0));

    // Standby: watchdog exits at once; qual 0 treated as 1 via enabled nmi
    enter(2'b01);
    wdint_n = 1'b0;
    @(negedge clk);
    wdint_n = 1'b1;
    check("R7 standby watchdog exit", exp_vec(4, 0));
    repeat (2) @(negedge clk);
    qual_cycles = 8'd0;
    nmi_en = 1'b1;
    enter(2'b01);
    nmi_n = 1'b0;
    @(negedge clk);
    nmi_n = 1'b1;
    check("R8 zero limit accepts in one edge", exp_vec(4, 0));
    repeat (2) @(negedge clk);

    // Halt with both upper encodings
    nmi_en = 1'b0;
    enter(2'b11);
    check("R5 halt clocks off", exp_vec(3, 0));
    irq_n = 1'b0; wdint_n = 1'b0; dbg_n = 1'b0; periph_wake_n = '0; nmi_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 halt ignores other wakes", exp_vec(3, 0));
    irq_n = 1'b1; wdint_n = 1'b1; dbg_n = 1'b1; periph_wake_n = '1;
    nmi_en = 1'b1;
    @(negedge clk);
    nmi_n = 1'b1;
    check("R9 halt exit on enabled nmi", exp_vec(4, 0));
    repeat (2) @(negedge clk);
    check("R10 halt resume pulse", exp_vec(0, 1));
    enter(2'b10);
    check("R2 mode 10 selects halt", exp_vec(3, 0));

    // Reset from a low-power mode
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    nmi_en = 1'b0;
    @(negedge clk);
    check("R1 reset leaves halt", exp_vec(0, 0));

    // Random phase against the bench model
    begin
      int s;
      s = $urandom(32'd4242);
      if (s < 0) $display("seed");
    end
    model_on = 1'b1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      check("R2 R3 R4 R5 R6 R7 R8 R9 R10 model", exp_vec(ms, mp));
      idle_req = ($urandom % 6) == 0;
      mode_sel = 2'($urandom);
      irq_n    = ($urandom % 25) != 0;
      wdint_n  = ($urandom % 60) != 0;
      dbg_n    = ($urandom % 60) != 0;
      nmi_n    = ($urandom % 30) != 0;
      if (($urandom % 50) == 0) nmi_en = ~nmi_en;
      if (($urandom % 100) == 0) wake_mask = NSRC'($urandom);
      if (($urandom % 100) == 0) qual_cycles = QW'($urandom % 8);
      for (int b = 0; b < NSRC; b++)
        if (($urandom % 8) == 0) periph_wake_n[b] = ($urandom % 3) != 0;
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule